// File: doc/BRIEF.md
# Scanned 4x4 Matrix Keypad Decoder

This block scans a sixteen-key matrix keypad and reports the most recently recognised key as a numeric code. A step timer produces a single-cycle enable once every `STEP_CYCLES` clocks. At 50 MHz the default of 500 gives one step every 10 us. On each step a one-hot column selector moves on by one position. The selector is driven out inverted, so exactly one column line is pulled low at any time, and the row lines come back low wherever a pressed key joins that column to a row.

On the same enable the row lines are registered, together with the column pattern that was driven for the whole step just ending. On the following enable that registered pair is decoded by a case over the column pattern, with nested row checks. The column line driven during the step is kept alongside the row sample so that the decoder always pairs the rows with the column that produced them, and not with the column that has just been selected. A row pattern with no low bit, or with more than one, leaves the output unchanged. The output therefore changes only on enable cycles and holds steady while a key is held.

Top module: `keypad_scanner`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `col_drive` = 4'b1110 and `key_code` = 0. The step counter also restarts, so the first enable comes `STEP_CYCLES` clocks after the last reset edge.
- R2: `col_drive` changes only at the clock edge that ends a step, and steps are exactly `STEP_CYCLES` clocks long.
- R3: `col_drive` steps through 1110, 1101, 1011, 0111 and then repeats from 1110. Bit 3 is the leftmost column of the keypad and bit 0 the rightmost.
- R4: Exactly one bit of `col_drive` is low in every cycle.
- R5: `row_in` is sampled only at the edge that ends a step. A key that is pressed and released between two such edges has no effect on `key_code`.
- R6: Take the rows sampled at the end of step k, with column c driven during that step. They set `key_code` at the end of step k+1. Row bit 3 is the top row and bit 0 the bottom row, and a low bit means pressed. The codes, listed top row to bottom row, are: left column 1, 4, 7, 10; second column 2, 5, 8, 0; third column 3, 6, 9, 11; right column 12, 13, 14, 15.
- R7: A row sample of 4'b1111, or one with two or more low bits, leaves `key_code` at its previous value.
- R8: `key_code` changes only at the clock edge that ends a step, or under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | 4 | Row return lines, active low, bit 3 = top row |
| col_drive | output | 4 | Column select lines, one low at a time, bit 3 = left column |
| key_code | output | CODE_W | Code of the last recognised key |

## Verification
The bench builds the scanner with `STEP_CYCLES` = 8 and `CODE_W` = 8. A full scan of four columns then takes 32 clocks, so every one of the sixteen keys can be pressed and confirmed through the two-step latency in a few hundred cycles. The short step also makes it cheap to place a two-cycle press strictly inside one step, and to reset while a key is held. The keypad itself is modelled in the bench: a row line is pulled low whenever its pressed key sits on the column currently driven low. Same-column double presses can therefore be produced, and they must not change the code.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
    localparam int KP_LINES = 4;
    typedef logic [KP_LINES-1:0] line_t;
    localparam line_t LINES_IDLE = '1;
    localparam line_t SEL_FIRST  = line_t'(1);
endpackage

// File: rtl/kp_step_timer.sv
module kp_step_timer #(
    parameter int STEP_CYCLES = 500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/kp_col_ring.sv
module kp_col_ring
    import keypad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    output line_t sel
);
    typedef struct packed {
        line_t ring;
    } ring_t;

    ring_t ring_d, ring_q;

    assign sel = ring_q.ring;

    always_comb begin
        ring_d = ring_q;
        if (advance) begin
            ring_d.ring[0] = ring_q.ring[KP_LINES-1];
            for (int i = 1; i < KP_LINES; i++) begin
                ring_d.ring[i] = ring_q.ring[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q.ring <= SEL_FIRST;
        end else begin
            ring_q <= ring_d;
        end
    end
endmodule

// File: rtl/kp_key_decode.sv
module kp_key_decode
    import keypad_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  line_t             col_code,
    input  line_t             row_code,
    output logic              hit,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        hit  = 1'b1;
        code = '0;
        case (col_code)
            4'b0111: begin
                if      (row_code == 4'b0111) code = CODE_W'(1);
                else if (row_code == 4'b1011) code = CODE_W'(4);
                else if (row_code == 4'b1101) code = CODE_W'(7);
                else if (row_code == 4'b1110) code = CODE_W'(10);
                else                          hit  = 1'b0;
            end
            4'b1011: begin
                if      (row_code == 4'b0111) code = CODE_W'(2);
                else if (row_code == 4'b1011) code = CODE_W'(5);
                else if (row_code == 4'b1101) code = CODE_W'(8);
                else if (row_code == 4'b1110) code = CODE_W'(0);
                else                          hit  = 1'b0;
            end
            4'b1101: begin
                if      (row_code == 4'b0111) code = CODE_W'(3);
                else if (row_code == 4'b1011) code = CODE_W'(6);
                else if (row_code == 4'b1101) code = CODE_W'(9);
                else if (row_code == 4'b1110) code = CODE_W'(11);
                else                          hit  = 1'b0;
            end
            4'b1110: begin
                if      (row_code == 4'b0111) code = CODE_W'(12);
                else if (row_code == 4'b1011) code = CODE_W'(13);
                else if (row_code == 4'b1101) code = CODE_W'(14);
                else if (row_code == 4'b1110) code = CODE_W'(15);
                else                          hit  = 1'b0;
            end
            default: begin
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import keypad_pkg::*;
#(
    parameter int STEP_CYCLES = 500,
    parameter int CODE_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        row_in,
    output logic [3:0]        col_drive,
    output logic [CODE_W-1:0] key_code
);
    typedef struct packed {
        line_t             rows;
        line_t             cols;
        logic [CODE_W-1:0] code;
    } samp_t;

    samp_t samp_d, samp_q;

    logic              step_tick;
    line_t             col_sel;
    logic              dec_hit;
    logic [CODE_W-1:0] dec_code;

    kp_step_timer #(
        .STEP_CYCLES(STEP_CYCLES)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(step_tick)
    );

    kp_col_ring u_ring (
        .clk    (clk),
        .rst    (rst),
        .advance(step_tick),
        .sel    (col_sel)
    );

    kp_key_decode #(
        .CODE_W(CODE_W)
    ) u_decode (
        .col_code(samp_q.cols),
        .row_code(samp_q.rows),
        .hit     (dec_hit),
        .code    (dec_code)
    );

    assign col_drive = ~col_sel;
    assign key_code  = samp_q.code;

    always_comb begin
        samp_d = samp_q;
        if (step_tick) begin
            samp_d.rows = row_in;
            samp_d.cols = col_drive;
            if (dec_hit) begin
                samp_d.code = dec_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q.rows <= LINES_IDLE;
            samp_q.cols <= ~SEL_FIRST;
            samp_q.code <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk #(
    parameter int STEP_CYCLES = 500,
    parameter int CODE_W      = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        col_drive,
    input logic [CODE_W-1:0] key_code,
    input logic              tick
);
    int gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (col_drive == 4'b1110) && (key_code == '0)); // R1

    AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == STEP_CYCLES - 1)); // R2

    AST_COL_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(col_drive) |-> ($past(tick) || $past(rst))); // R2

    AST_COL_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(col_drive))
            |-> (col_drive == {$past(col_drive[2:0]), $past(col_drive[3])})); // R3

    AST_ONE_COL_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~col_drive) == 1); // R4

    AST_CODE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(key_code) |-> ($past(tick) || $past(rst))); // R8
endmodule

bind keypad_scanner keypad_scanner_chk #(
    .STEP_CYCLES(STEP_CYCLES),
    .CODE_W     (CODE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .col_drive(col_drive),
    .key_code (key_code),
    .tick     (step_tick)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
    localparam int STEP = 8;
    localparam int CW   = 8;
    localparam int KT [16] = '{1, 2, 3, 12, 4, 5, 6, 13, 7, 8, 9, 14, 10, 0, 11, 15};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    row_in;
    logic [3:0]    col_drive;
    logic [CW-1:0] key_code;

    int ka_r = -1, ka_c = -1, kb_r = -1, kb_c = -1;
    int n_chk = 0, n_bad = 0;

    keypad_scanner #(.STEP_CYCLES(STEP), .CODE_W(CW)) uut (
        .clk(clk), .rst(rst), .row_in(row_in),
        .col_drive(col_drive), .key_code(key_code)
    );

    always #10 clk = ~clk;

    // keypad model: a pressed key pulls its row low while its column is low
    always @* begin
        row_in = 4'hF;
        if (ka_r >= 0 && col_drive[3-ka_c] == 1'b0) row_in[3-ka_r] = 1'b0;
        if (kb_r >= 0 && col_drive[3-kb_c] == 1'b0) row_in[3-kb_r] = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int decode(input int colpos, input logic [3:0] rows);
        int lows = 0;
        int rp = 0;
        for (int j = 0; j < 4; j++) begin
            if (rows[j] == 1'b0) begin
                lows++;
                rp = 3 - j;
            end
        end
        if (lows != 1) return -1;
        return KT[rp*4 + colpos];
    endfunction

    // reference model, advanced at each falling edge for the preceding rising edge
    int         m_cnt = 0, m_col = 0, m_cs = 3, m_code = 0;
    logic [3:0] m_rows = 4'hF, cap_rows = 4'hF;
    logic       cap_rst = 1'b1;

    always @(negedge clk) begin
        if (cap_rst) begin
            m_cnt = 0; m_col = 0; m_cs = 3; m_code = 0; m_rows = 4'hF;
        end else if (m_cnt == STEP - 1) begin
            int d;
            d = decode(m_cs, m_rows);
            if (d >= 0) m_code = d;
            m_rows = cap_rows;
            m_cs   = 3 - m_col;
            m_col  = (m_col + 1) % 4;
            m_cnt  = 0;
        end else begin
            m_cnt++;
        end
        chk(col_drive == ~(4'b0001 << m_col), "R2 R3 col_drive", int'(col_drive), int'(~(4'b0001 << m_col) & 4'hF));
        chk(int'(key_code) == m_code, "R6 R7 R8 key_code", int'(key_code), m_code);
        chk($countones(~col_drive) == 1, "R4 one column low", $countones(~col_drive), 1);
        cap_rows = row_in;
        cap_rst  = rst;
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(col_drive == 4'b1110, "R1 col after reset", int'(col_drive), 14);
        chk(key_code == '0, "R1 code after reset", int'(key_code), 0);
        cycles(1);

        // R6: every key in turn
        for (int k = 0; k < 16; k++) begin
            ka_r = k / 4; ka_c = k % 4;
            cycles(12 * STEP);
            chk(int'(key_code) == KT[k], "R6 key decode", int'(key_code), KT[k]);
        end

        // R7: release holds the last code
        ka_r = -1; ka_c = -1;
        cycles(12 * STEP);
        chk(int'(key_code) == 15, "R7 hold on no key", int'(key_code), 15);

        // R7: two keys in one column hold the code
        ka_r = 3; ka_c = 1;
        cycles(12 * STEP);
        chk(int'(key_code) == 0, "R6 key zero", int'(key_code), 0);
        ka_r = 0; ka_c = 0; kb_r = 1; kb_c = 0;
        cycles(12 * STEP);
        chk(int'(key_code) == 0, "R7 hold on multiple rows", int'(key_code), 0);
        ka_r = -1; ka_c = -1; kb_r = -1; kb_c = -1;
        cycles(12 * STEP);

        // R5: a short press inside a step is never sampled
        begin
            logic [3:0] prev;
            prev = col_drive;
            for (int t = 0; t < 4 * STEP; t++) begin
                cycles(1);
                if (col_drive != prev && col_drive == 4'b0111) break;
                prev = col_drive;
            end
        end
        ka_r = 0; ka_c = 0;
        cycles(2);
        ka_r = -1; ka_c = -1;
        cycles(12 * STEP);
        chk(int'(key_code) == 0, "R5 short press ignored", int'(key_code), 0);

        // R1: reset while a key is held
        ka_r = 2; ka_c = 2;
        cycles(12 * STEP);
        chk(int'(key_code) == 9, "R6 key nine", int'(key_code), 9);
        rst = 1'b1;
        cycles(2);
        chk(col_drive == 4'b1110, "R1 col under reset", int'(col_drive), 14);
        chk(key_code == '0, "R1 code under reset", int'(key_code), 0);
        rst = 1'b0;
        cycles(12 * STEP);
        chk(int'(key_code) == 9, "R6 key nine after reset", int'(key_code), 9);

        finish_run();
    end
endmodule